// File: doc/BRIEF.md
# Memory Access Response Watchdog

This block guards the handshake between a controller and its message memory. When an access begins, a down-counter is loaded with a programmed timeout value. It then counts one step per bus clock while the access is outstanding. If the memory answers with its ready response, the counter is reloaded with the programmed value and stops, waiting for the next access. If the counter gets to zero first, it halts there and raises a sticky timeout flag, which software clears by writing a one.

The counter value is brought out as a status field. A programmed value of zero turns the watchdog off: the counter stays at zero and never arms. An access that starts while a count is running, or after a timeout, loads the counter again from the programmed value.

Top module: `mem_resp_wdog`

## Requirements
- R1: While reset is high and on the first cycle after it, `wd_count` is 0 and `wd_flag` is 0.
- R2: An `acc_start` pulse with a nonzero `wd_limit` on an idle watchdog makes `wd_count` equal `wd_limit` after that clock edge.
- R3: While an access is outstanding and no other event applies, `wd_count` drops by exactly one per clock.
- R4: `mem_ready` during an outstanding access reloads `wd_count` with `wd_limit` and stops the count. The value then holds until the next `acc_start`.
- R5: After a timeout, `wd_count` stays at 0 and does not wrap until a new access starts.
- R6: `wd_flag` goes to 1 on the same clock edge on which an outstanding count steps from 1 to 0.
- R7: `wd_flag` stays at 1 until `flag_clr` is 1 at a clock edge, which clears it. A timeout on the same edge as `flag_clr` leaves the flag at 1.
- R8: With `wd_limit` equal to 0, the counter goes to 0 at the next edge and never arms. `acc_start` then has no effect and the flag is never set.
- R9: `acc_start` after a timeout re-arms the counter from `wd_limit`. The flag keeps its value.
- R10: `mem_ready` while no access is outstanding leaves `wd_count` and `wd_flag` unchanged.
- R11: `acc_start` during an outstanding count restarts it from `wd_limit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral bus clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_start | input | 1 | One-cycle pulse marking the start of a memory access |
| mem_ready | input | 1 | Completion response from the memory |
| wd_limit | input | CNT_W | Programmed timeout value; 0 disables the watchdog |
| flag_clr | input | 1 | Write-one-to-clear strobe for the timeout flag |
| wd_count | output | CNT_W | Current counter value (status) |
| wd_flag | output | 1 | Sticky timeout flag |

## Verification
A wrong armed bit or counter value shows up on `wd_count` one clock after the edge that caused it. Examples are a missed decrement, a reload that does not happen, or a count that wraps past zero. A count that keeps running after `mem_ready` is seen on the next cycle, when the value moves although it should hold. A timeout decision that is off by a step shows up as `wd_flag` rising one edge early or late compared with the moment the count reaches zero. A wrong clear or set priority shows up on the edge where the flag should have held or dropped.

// File: rtl/mrw_pkg.sv
package mrw_pkg;
  // One action is chosen per clock edge, in priority order.
  typedef enum logic [2:0] {
    ACT_HOLD   = 3'd0,
    ACT_OFF    = 3'd1,
    ACT_LOAD   = 3'd2,
    ACT_RELOAD = 3'd3,
    ACT_DEC    = 3'd4,
    ACT_EXPIRE = 3'd5
  } wd_act_e;
endpackage

// File: rtl/mrw_ctrl.sv
module mrw_ctrl #(
  parameter int CNT_W = 8
) (
  input  logic             acc_start,
  input  logic             mem_ready,
  input  logic [CNT_W-1:0] wd_limit,
  input  logic             armed,
  input  logic [CNT_W-1:0] cnt,
  output mrw_pkg::wd_act_e act
);
  import mrw_pkg::*;

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic disabled;
  assign disabled = (wd_limit == '0);

  always_comb begin
    act = ACT_HOLD;
    if (disabled)              act = ACT_OFF;
    else if (acc_start)        act = ACT_LOAD;
    else if (armed) begin
      if (mem_ready)           act = ACT_RELOAD;
      else if (cnt <= ONE)     act = ACT_EXPIRE;
      else                     act = ACT_DEC;
    end
  end
endmodule

// File: rtl/mrw_counter.sv
module mrw_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  mrw_pkg::wd_act_e act,
  input  logic [CNT_W-1:0] wd_limit,
  output logic [CNT_W-1:0] cnt,
  output logic             armed,
  output logic             expire
);
  import mrw_pkg::*;

  assign expire = (act == ACT_EXPIRE);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      armed <= 1'b0;
    end else begin
      unique case (act)
        ACT_OFF: begin
          cnt   <= '0;
          armed <= 1'b0;
        end
        ACT_LOAD: begin
          cnt   <= wd_limit;
          armed <= 1'b1;
        end
        ACT_RELOAD: begin
          cnt   <= wd_limit;
          armed <= 1'b0;
        end
        ACT_DEC: begin
          cnt   <= cnt - CNT_W'(1);
        end
        ACT_EXPIRE: begin
          cnt   <= '0;
          armed <= 1'b0;
        end
        default: begin
          cnt   <= cnt;
        end
      endcase
    end
  end
endmodule

// File: rtl/mrw_flag.sv
module mrw_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst)        flag <= 1'b0;
    else if (set_i) flag <= 1'b1;
    else if (clr_i) flag <= 1'b0;
  end
endmodule

// File: rtl/mem_resp_wdog.sv
module mem_resp_wdog #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc_start,
  input  logic             mem_ready,
  input  logic [CNT_W-1:0] wd_limit,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] wd_count,
  output logic             wd_flag
);
  import mrw_pkg::*;

  wd_act_e          act;
  logic [CNT_W-1:0] cnt;
  logic             armed;
  logic             expire;

  mrw_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .acc_start (acc_start),
    .mem_ready (mem_ready),
    .wd_limit  (wd_limit),
    .armed     (armed),
    .cnt       (cnt),
    .act       (act)
  );

  mrw_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .act      (act),
    .wd_limit (wd_limit),
    .cnt      (cnt),
    .armed    (armed),
    .expire   (expire)
  );

  mrw_flag u_flag (
    .clk   (clk),
    .rst   (rst),
    .set_i (expire),
    .clr_i (flag_clr),
    .flag  (wd_flag)
  );

  assign wd_count = cnt;
endmodule

// File: rtl/mrw_checker.sv
module mrw_checker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             acc_start,
  input logic             mem_ready,
  input logic [CNT_W-1:0] wd_limit,
  input logic             flag_clr,
  input logic [CNT_W-1:0] wd_count,
  input logic             wd_flag
);
  AST_RESET_CLEAN: assert property (@(posedge clk) rst |=> (wd_count == '0 && !wd_flag)); // R1
  AST_START_LOADS: assert property (@(posedge clk) disable iff (rst)
    (acc_start && wd_limit != '0) |=> wd_count == $past(wd_limit)); // R2
  AST_ZERO_STICKS: assert property (@(posedge clk) disable iff (rst)
    (wd_count == '0 && !acc_start) |=> wd_count == '0); // R5
  AST_FLAG_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    $rose(wd_flag) |-> wd_count == '0); // R6
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (wd_flag && !flag_clr) |=> wd_flag); // R7
  AST_OFF_WHEN_ZERO: assert property (@(posedge clk) disable iff (rst)
    (wd_limit == '0) |=> (wd_count == '0 && !$rose(wd_flag))); // R8
endmodule

bind mem_resp_wdog mrw_checker #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .acc_start (acc_start),
  .mem_ready (mem_ready),
  .wd_limit  (wd_limit),
  .flag_clr  (flag_clr),
  .wd_count  (wd_count),
  .wd_flag   (wd_flag)
);

// File: tb/mem_resp_wdog_bench.sv
module mem_resp_wdog_bench;
  localparam int CNT_W = 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             acc_start = 1'b0;
  logic             mem_ready = 1'b0;
  logic [CNT_W-1:0] wd_limit = '0;
  logic             flag_clr = 1'b0;
  logic [CNT_W-1:0] wd_count;
  logic             wd_flag;

  int n_cmp = 0;
  int n_bad = 0;

  // model state after the last clock edge
  logic [CNT_W-1:0] m_cnt = '0;
  logic             m_arm = 1'b0;
  logic             m_flg = 1'b0;
  string            m_tag = "R1";
  string            f_tag = "R1";

  always #10 clk = ~clk;

  mem_resp_wdog #(.CNT_W(CNT_W)) u_mem_resp_wdog (
    .clk(clk), .rst(rst), .acc_start(acc_start), .mem_ready(mem_ready),
    .wd_limit(wd_limit), .flag_clr(flag_clr), .wd_count(wd_count), .wd_flag(wd_flag)
  );

  task automatic chk(string tag, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // expected next state from the requirements
  task automatic model_step(logic st, logic rdy, logic [CNT_W-1:0] ld, logic clr);
    logic fset;
    fset = 1'b0;
    if (ld == '0) begin
      m_cnt = '0; m_arm = 1'b0; m_tag = "R8";
    end else if (st) begin
      m_tag = m_arm ? "R11" : (m_flg ? "R9" : "R2");
      m_cnt = ld; m_arm = 1'b1;
    end else if (m_arm && rdy) begin
      m_cnt = ld; m_arm = 1'b0; m_tag = "R4";
    end else if (m_arm) begin
      if (m_cnt == 1) begin
        m_cnt = '0; m_arm = 1'b0; fset = 1'b1; m_tag = "R6";
      end else begin
        m_cnt = m_cnt - 1; m_tag = "R3";
      end
    end else begin
      m_tag = rdy ? "R10" : "R5";
    end
    if (fset) begin
      m_flg = 1'b1; f_tag = "R6";
    end else if (clr) begin
      m_flg = 1'b0; f_tag = "R7";
    end else begin
      f_tag = m_flg ? "R7" : m_tag;
    end
  endtask

  // compare the previous edge's result, then drive the next inputs
  task automatic step(logic st, logic rdy, logic [CNT_W-1:0] ld, logic clr);
    @(negedge clk);
    chk(m_tag, "wd_count", int'(wd_count), int'(m_cnt));
    chk(f_tag, "wd_flag", int'(wd_flag), int'(m_flg));
    acc_start = st; mem_ready = rdy; wd_limit = ld; flag_clr = clr;
    model_step(st, rdy, ld, clr);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk("R1", "wd_count in reset", int'(wd_count), 0);
    chk("R1", "wd_flag in reset", int'(wd_flag), 0);
    @(negedge clk);
    rst = 1'b0;
    wd_limit = 8'd5;
    m_cnt = '0; m_arm = 1'b0; m_flg = 1'b0; m_tag = "R1"; f_tag = "R1";

    // R2/R3/R6/R5: full timeout with limit 5
    step(1, 0, 8'd5, 0);
    for (int i = 0; i < 8; i++) step(0, 0, 8'd5, 0);
    // R7: clear the flag, then hold
    step(0, 0, 8'd5, 1);
    step(0, 0, 8'd5, 0);
    // R9: re-arm after timeout; R7 set wins over clear at expiry
    step(1, 0, 8'd3, 0);
    step(0, 0, 8'd3, 0);
    step(0, 0, 8'd3, 0);
    step(0, 0, 8'd3, 1);
    step(0, 0, 8'd3, 0);
    // R4: ready reloads and holds; R10: ready while idle
    step(1, 0, 8'd6, 1);
    step(0, 0, 8'd6, 0);
    step(0, 1, 8'd6, 0);
    for (int i = 0; i < 3; i++) step(0, 1, 8'd6, 0);
    // R11: restart mid-count
    step(1, 0, 8'd4, 0);
    step(0, 0, 8'd4, 0);
    step(1, 0, 8'd9, 0);
    step(0, 0, 8'd9, 0);
    // R8: zero limit disables, start ignored
    step(0, 0, 8'd0, 0);
    step(1, 0, 8'd0, 0);
    for (int i = 0; i < 4; i++) step(0, 0, 8'd0, 0);
    // R6 at limit 1
    step(1, 0, 8'd1, 0);
    step(0, 0, 8'd1, 0);
    step(0, 0, 8'd1, 1);

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      logic [CNT_W-1:0] ld;
      logic st, rdy, clr;
      ld  = (($urandom % 10) == 0) ? '0 : CNT_W'(1 + ($urandom % 12));
      st  = (($urandom % 9) == 0);
      rdy = (($urandom % 7) == 0);
      clr = (($urandom % 11) == 0);
      step(st, rdy, ld, clr);
    end
    step(0, 0, 8'd4, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule